// File: doc/BRIEF.md
# Two-Master Doubleword-Interleaved Memory Router

This block sits between two bus masters, typically a processor and a DMA engine, and a memory that is split into two independent ports. Consecutive 64-bit doublewords live on alternating ports, chosen by byte address bit 3. Each master presents a 64-bit read or write with byte enables over a valid/ready handshake. The router decodes the address, steers the request to its port, and returns read data to the right master one cycle later. Two masters that target different ports are both served in the same cycle. When both target the same port, a round-robin arbiter picks one and stalls the other.

The addressable space is 256 KB, split into 128 KB per port. A port therefore sees 16K doublewords, indexed by the byte address with the interleave bit and the byte offset removed. Master addresses are wider than the space. An access that falls beyond it is accepted at once and answered with an error, and it never reaches a port. The memory arrays behind the ports are outside the block. Each port is expected to return registered read data one cycle after a read enable.

Top module: `ilv_mem_router`

## Requirements
- R1: A request whose byte address bit 3 is 0 is issued on port 0, and one whose bit 3 is 1 is issued on port 1.
- R2: The doubleword index driven on a port equals byte address bits [17:4] of the granted request.
- R3: When both masters request in-range addresses on different ports in one cycle, both see ready high in that cycle.
- R4: When both masters request the same port, exactly one is granted. The other sees ready low and is granted in the next cycle if it holds its request.
- R5: On contention for a port, master 0 wins the first contention after reset. After that, the master that lost the previous contention on that port wins.
- R6: An accepted in-range read raises that master's read-valid for exactly the next cycle, carrying the doubleword stored at the address. Read-valid and error are never raised together.
- R7: On a write, byte-enable bit i covers data bits [8i+7:8i]. Only the enabled bytes of the addressed doubleword change.
- R8: A request with any address bit at or above bit 18 set is accepted in the cycle it is presented. It raises that master's error output in the next cycle, with read-valid low, and asserts no port enable and changes no memory.
- R9: A master whose valid is low sees ready low. After reset, all ready, read-valid, error and port-enable outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 2 | Request valid, one bit per master |
| m_we | input | 2 | 1 = write, 0 = read, per master |
| m_addr | input | 2x20 | Byte address per master |
| m_wdata | input | 2x64 | Write data per master |
| m_be | input | 2x8 | Byte enables per master |
| m_ready | output | 2 | Request accepted this cycle |
| m_rvalid | output | 2 | Read data valid, one cycle after acceptance |
| m_err | output | 2 | Out-of-range response, one cycle after acceptance |
| m_rdata | output | 2x64 | Read data per master |
| p_en | output | 2 | Port access enable, one bit per port |
| p_we | output | 2 | Port write enable |
| p_idx | output | 2x14 | Doubleword index within the port |
| p_wdata | output | 2x64 | Port write data |
| p_be | output | 2x8 | Port byte enables |
| p_rdata | input | 2x64 | Registered read data from each port |

## Verification
The assertions assume that a master which sees ready low keeps its valid, address, direction and data unchanged until it is accepted. They also assume that valid stays low during reset and that each port returns read data one clock after its read enable. The bench drives requests only through a task that holds every field stable until ready is seen. It deasserts valid only for the masters that were accepted, and it models each port as a registered array that updates its read output only on a read enable. Out-of-range stimulus sets only bits 18 or 19, so the in-range address checks are not disturbed.

// File: rtl/ilv_router_pkg.sv
package ilv_router_pkg;
   // Requester identity, also the arbiter's favoured-master encoding
   typedef enum logic {MST_A = 1'b0, MST_B = 1'b1} mst_e;

   // Width of the in-port doubleword index for a given space and lane size
   function automatic int idx_width(input int addr_w, input int lane_bits);
      return addr_w - lane_bits - 1;
   endfunction
endpackage

// File: rtl/ilv_dec.sv
module ilv_dec #(
   parameter int MADDR_W = 20,
   parameter int ADDR_W  = 18,
   parameter int LANE_B  = 3,
   localparam int IDX_W  = ADDR_W - LANE_B - 1
) (
   input  logic               valid,
   input  logic [MADDR_W-1:0] addr,
   output logic [1:0]         hit,
   output logic               oor,
   output logic [IDX_W-1:0]   idx
);
   generate
      if (MADDR_W > ADDR_W) begin : g_range
         assign oor = |addr[MADDR_W-1:ADDR_W];
      end else begin : g_full
         assign oor = 1'b0;
      end
   endgenerate

   assign idx = addr[ADDR_W-1:LANE_B+1];

   always_comb begin
      hit = '0;
      if (valid && !oor) hit[addr[LANE_B]] = 1'b1;
   end
endmodule

// File: rtl/ilv_rr_arb.sv
module ilv_rr_arb
   import ilv_router_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   mst_e fav;
   logic both;

   assign both = &req;

   always_comb begin
      if (both) gnt = (fav == MST_B) ? 2'b10 : 2'b01;
      else      gnt = req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    fav <= MST_A;
      else if (both) fav <= (fav == MST_A) ? MST_B : MST_A;
   end

   // R4
   one_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R4
   gnt_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == 2'b00);
   // R4
   no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != 2'b00) |-> (gnt != 2'b00));
   // R5
   alt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both && $past(both)) |-> (gnt != $past(gnt)));
endmodule

// File: rtl/ilv_mem_router.sv
module ilv_mem_router
   import ilv_router_pkg::*;
#(
   parameter int MADDR_W = 20,
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 64,
   localparam int BE_W   = DATA_W / 8,
   localparam int LANE_B = $clog2(BE_W),
   localparam int IDX_W  = ADDR_W - LANE_B - 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  m_valid,
   input  logic [1:0]                  m_we,
   input  logic [1:0][MADDR_W-1:0]     m_addr,
   input  logic [1:0][DATA_W-1:0]      m_wdata,
   input  logic [1:0][BE_W-1:0]        m_be,
   output logic [1:0]                  m_ready,
   output logic [1:0]                  m_rvalid,
   output logic [1:0]                  m_err,
   output logic [1:0][DATA_W-1:0]      m_rdata,
   output logic [1:0]                  p_en,
   output logic [1:0]                  p_we,
   output logic [1:0][IDX_W-1:0]       p_idx,
   output logic [1:0][DATA_W-1:0]      p_wdata,
   output logic [1:0][BE_W-1:0]        p_be,
   input  logic [1:0][DATA_W-1:0]      p_rdata
);
   initial begin
      assert (DATA_W % 8 == 0 && (1 << LANE_B) == BE_W)
         else $error("DATA_W must be a power-of-two number of bytes");
      assert (MADDR_W >= ADDR_W && ADDR_W > LANE_B + 1)
         else $error("address widths inconsistent");
      assert (IDX_W == idx_width(ADDR_W, LANE_B))
         else $error("index width mismatch");
   end

   logic [1:0]       hit   [2];
   logic [1:0]       oor;
   logic [IDX_W-1:0] idx_m [2];
   logic [1:0]       gnt_p [2];
   logic [1:0]       rd_q, err_q, port_q;

   genvar gm, gp;
   generate
      for (gm = 0; gm < 2; gm++) begin : g_mst
         ilv_dec #(.MADDR_W(MADDR_W), .ADDR_W(ADDR_W), .LANE_B(LANE_B)) u_dec (
            .valid (m_valid[gm]),
            .addr  (m_addr[gm]),
            .hit   (hit[gm]),
            .oor   (oor[gm]),
            .idx   (idx_m[gm])
         );

         assign m_ready[gm] = gnt_p[0][gm] | gnt_p[1][gm] | (m_valid[gm] & oor[gm]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q[gm]   <= 1'b0;
               err_q[gm]  <= 1'b0;
               port_q[gm] <= 1'b0;
            end else begin
               rd_q[gm]   <= m_ready[gm] & ~m_we[gm] & ~oor[gm];
               err_q[gm]  <= m_valid[gm] & oor[gm];
               port_q[gm] <= m_addr[gm][LANE_B];
            end
         end

         assign m_rvalid[gm] = rd_q[gm];
         assign m_err[gm]    = err_q[gm];
         assign m_rdata[gm]  = rd_q[gm] ? p_rdata[port_q[gm]] : '0;

         // R8
         oor_noport_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[gm] && oor[gm]) |-> (m_ready[gm] && !gnt_p[0][gm] && !gnt_p[1][gm]));
         // R8
         err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[gm] && oor[gm]) |=> (m_err[gm] && !m_rvalid[gm]));
         // R6
         rd_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[gm] && m_ready[gm] && !m_we[gm] && !oor[gm]) |=> m_rvalid[gm]);
         // R9
         idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !m_valid[gm] |-> !m_ready[gm]);
      end

      for (gp = 0; gp < 2; gp++) begin : g_port
         logic sel;
         ilv_rr_arb u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   ({hit[1][gp], hit[0][gp]}),
            .gnt   (gnt_p[gp])
         );
         assign sel          = gnt_p[gp][1];
         assign p_en[gp]     = |gnt_p[gp];
         assign p_we[gp]     = p_en[gp] & m_we[sel];
         assign p_idx[gp]    = idx_m[sel];
         assign p_wdata[gp]  = m_wdata[sel];
         assign p_be[gp]     = m_be[sel];
      end
   endgenerate

   // R3
   par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid == 2'b11 && oor == 2'b00 && m_addr[0][LANE_B] != m_addr[1][LANE_B])
         |-> (m_ready == 2'b11));
   // R6
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rvalid & m_err) == 2'b00);
endmodule

// File: tb/sim_ilv_mem_router.sv
module sim_ilv_mem_router;
   localparam int MADDR_W = 20, ADDR_W = 18, DATA_W = 64, BE_W = 8, IDX_W = 14;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]                 m_valid = '0, m_we = '0;
   logic [1:0][MADDR_W-1:0]    m_addr = '0;
   logic [1:0][DATA_W-1:0]     m_wdata = '0;
   logic [1:0][BE_W-1:0]       m_be = '0;
   logic [1:0]                 m_ready, m_rvalid, m_err, p_en, p_we;
   logic [1:0][DATA_W-1:0]     m_rdata, p_wdata;
   logic [1:0][DATA_W-1:0]     p_rdata = '0;
   logic [1:0][IDX_W-1:0]      p_idx;
   logic [1:0][BE_W-1:0]       p_be;

   ilv_mem_router u0 (.*);

   // port memories, registered read
   logic [DATA_W-1:0] pm [2][1<<IDX_W];
   initial for (int p = 0; p < 2; p++) for (int i = 0; i < (1<<IDX_W); i++) pm[p][i] = '0;
   always @(posedge clk) begin
      for (int p = 0; p < 2; p++) if (p_en[p]) begin
         if (p_we[p]) begin
            for (int b = 0; b < BE_W; b++) if (p_be[p][b]) pm[p][p_idx[p]][8*b +: 8] <= p_wdata[p][8*b +: 8];
         end else p_rdata[p] <= pm[p][p_idx[p]];
      end
   end

   int cyc = 0;
   always @(posedge clk) cyc++;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // flat byte reference model
   logic [7:0] refm [int unsigned];
   function automatic logic [63:0] ref_rd(logic [MADDR_W-1:0] a);
      logic [63:0] d;
      for (int b = 0; b < 8; b++) begin
         int unsigned k = {a[MADDR_W-1:3], 3'b000} + b;
         d[8*b +: 8] = refm.exists(k) ? refm[k] : 8'h00;
      end
      return d;
   endfunction
   function automatic void ref_wr(logic [MADDR_W-1:0] a, logic [63:0] d, logic [7:0] be);
      for (int b = 0; b < 8; b++) if (be[b]) refm[{a[MADDR_W-1:3], 3'b000} + b] = d[8*b +: 8];
   endfunction

   typedef struct { bit err; logic [63:0] d; int stamp; } exp_t;
   exp_t eq0[$], eq1[$];

   function automatic void accept(int m);
      exp_t e;
      e.stamp = cyc; e.err = 0; e.d = '0;
      if (m_addr[m][MADDR_W-1:ADDR_W] != 0) e.err = 1;
      else if (m_we[m]) begin ref_wr(m_addr[m], m_wdata[m], m_be[m]); return; end
      else e.d = ref_rd(m_addr[m]);
      if (m == 0) eq0.push_back(e); else eq1.push_back(e);
   endfunction

   // monitor: scoreboard pop and compare
   always @(negedge clk) if (rst_n) begin
      for (int m = 0; m < 2; m++) if (m_rvalid[m] || m_err[m]) begin
         exp_t e;
         if ((m == 0 ? eq0.size() : eq1.size()) == 0) chk("R6 unexpected response", 1, 0);
         else begin
            if (m == 0) e = eq0.pop_front(); else e = eq1.pop_front();
            if (e.err) chk("R8 error response kind", {m_err[m], m_rvalid[m]}, 2'b10);
            else       chk("R6 read response kind", {m_err[m], m_rvalid[m]}, 2'b01);
            chk("R6 response latency", cyc, e.stamp + 1);
            if (!e.err) chk("R6 read data", m_rdata[m], e.d);
         end
      end
   end

   task automatic req(int m, bit we, logic [MADDR_W-1:0] a, logic [63:0] d, logic [7:0] be);
      m_we[m] = we; m_addr[m] = a; m_wdata[m] = d; m_be[m] = be; m_valid[m] = 1'b1;
   endtask

   // driver: hold every request until accepted
   task automatic run(output int ncyc, output logic [1:0] rdy1, output logic [1:0] pen1);
      bit first = 1;
      logic [1:0] acc;
      ncyc = 0;
      while (m_valid != 2'b00) begin
         #1;
         if (first) begin rdy1 = m_ready; pen1 = p_en; first = 0; end
         acc = m_valid & m_ready;
         for (int m = 0; m < 2; m++) if (acc[m]) accept(m);
         @(posedge clk); @(negedge clk);
         m_valid = m_valid & ~acc;
         ncyc++;
      end
   endtask

   task automatic finish_sim();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_sim();
   end

   initial begin
      int n; logic [1:0] r1, pe;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 ready in reset", m_ready, 0);
      chk("R9 rvalid/err in reset", {m_rvalid, m_err}, 0);
      chk("R9 port enable in reset", p_en, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R9 idle outputs", {m_ready, m_rvalid, m_err, p_en}, 0);
      @(negedge clk);

      // R1 / R2 steering and index
      req(0, 1, 20'h00030, 64'hA1A2A3A4A5A6A7A8, 8'hFF); run(n, r1, pe);
      req(0, 1, 20'h00038, 64'hB1B2B3B4B5B6B7B8, 8'hFF); run(n, r1, pe);
      req(0, 1, 20'h3FFF8, 64'hC1C2C3C4C5C6C7C8, 8'hFF); run(n, r1, pe);
      req(1, 1, 20'h00008, 64'h0123456789ABCDEF, 8'hFF); run(n, r1, pe);
      chk("R1 bit3=1 lands on port 1", pe, 2'b10);
      @(negedge clk);
      chk("R2 port0 index 3", pm[0][3], 64'hA1A2A3A4A5A6A7A8);
      chk("R1 port1 index 3", pm[1][3], 64'hB1B2B3B4B5B6B7B8);
      chk("R2 port1 top index", pm[1][14'h3FFF], 64'hC1C2C3C4C5C6C7C8);
      chk("R1 port1 index 0", pm[1][0], 64'h0123456789ABCDEF);
      chk("R1 port0 index 0 untouched", pm[0][0], 64'h0);

      // R6 reads
      req(1, 0, 20'h00030, 0, 0); run(n, r1, pe);
      req(1, 0, 20'h3FFF8, 0, 0); run(n, r1, pe);

      // R3 parallel on different ports
      req(0, 1, 20'h00040, 64'h1111, 8'hFF); req(1, 1, 20'h00048, 64'h2222, 8'hFF);
      run(n, r1, pe);
      chk("R3 both ready same cycle", r1, 2'b11);
      chk("R3 single cycle", n, 1);
      req(0, 0, 20'h00048, 0, 0); req(1, 0, 20'h00040, 0, 0);
      run(n, r1, pe);
      chk("R3 parallel reads ready", r1, 2'b11);

      // R4 / R5 contention
      req(0, 1, 20'h00060, 64'h6060, 8'hFF); req(1, 1, 20'h00070, 64'h7070, 8'hFF);
      run(n, r1, pe);
      chk("R5 first contention to master 0", r1, 2'b01);
      chk("R4 loser served next cycle", n, 2);
      req(0, 0, 20'h00068, 0, 0); req(1, 0, 20'h00078, 0, 0);
      run(n, r1, pe);
      chk("R4 port1 independent first contention", r1, 2'b01);
      req(0, 0, 20'h00070, 0, 0); req(1, 0, 20'h00060, 0, 0);
      run(n, r1, pe);
      chk("R5 previous loser wins port0", r1, 2'b10);
      chk("R4 two cycles", n, 2);
      req(0, 0, 20'h00060, 0, 0); req(1, 0, 20'h00070, 0, 0);
      run(n, r1, pe);
      chk("R5 alternation back to master 0", r1, 2'b01);

      // R7 byte enables
      req(0, 1, 20'h00080, 64'hFFFFFFFFFFFFFFFF, 8'hFF); run(n, r1, pe);
      req(0, 1, 20'h00080, 64'h0, 8'b0101_0101); run(n, r1, pe);
      @(negedge clk);
      chk("R7 enabled bytes only", pm[0][8], 64'hFF00FF00FF00FF00);
      req(1, 0, 20'h00080, 0, 0); run(n, r1, pe);

      // R8 out of range
      req(0, 1, 20'h40080, 64'h0, 8'hFF); run(n, r1, pe);
      chk("R8 accepted at once", r1, 2'b01);
      chk("R8 no port enable", pe, 2'b00);
      @(negedge clk);
      chk("R8 memory unchanged", pm[0][8], 64'hFF00FF00FF00FF00);
      req(0, 0, 20'h80080, 0, 0); req(1, 0, 20'h00080, 0, 0);
      run(n, r1, pe);
      chk("R8 no contention with in-range", r1, 2'b11);
      chk("R8 only in-range master on port", pe, 2'b01);

      // mixed traffic
      for (int it = 0; it < 300; it++) begin
         for (int m = 0; m < 2; m++) if ($urandom_range(0, 3) != 0) begin
            logic [MADDR_W-1:0] a;
            a = {8'h0, 9'($urandom_range(0, 511)), 3'b000} & 20'h001F8;
            if ($urandom_range(0, 9) == 0) a[18 + $urandom_range(0, 1)] = 1'b1;
            req(m, $urandom_range(0, 1), a, {$urandom, $urandom}, 8'($urandom));
         end
         run(n, r1, pe);
      end
      repeat (3) @(negedge clk);
      chk("R6 all responses returned", eq0.size() + eq1.size(), 0);
      for (int a = 0; a < 512; a += 8)
         chk("R1 placement vs reference", pm[a[3]][a >> 4], ref_rd(20'(a)));
      finish_sim();
   end
endmodule